// File: doc/BRIEF.md
# Dual-Action Capture/Compare Timer Channel

This block is one timer channel with two actions, A and B, that share one of two external 16-bit time-base counts. In the input modes it time-stamps edges on a synchronized input pin. It can take a single capture, measure a pulse width, or measure a period. In the output modes it drives an output flip-flop from compare matches. It can do a single compare on A, a set/clear pair on A and B, or a buffered pulse-width-modulated waveform.

Channel B holds two physical registers. In PWM mode software reads and writes the front register (B1). The comparator uses the back register (B2), which is loaded from B1 at each period start, so a duty change never cuts a period short. In the capture modes B1 holds an edge time until the measurement completes. In the compare modes B2 is written directly. A small register bus reaches A, B and a status word. A status flag marks the completion of a measurement or output cycle and drives an interrupt request.

Top module: `dual_action_timer`

## Requirements
- R1: After reset, registers A and B and the status word read 0, `pin_out` is 0 and `irq` is 0. Bus addresses: 0 = A, 1 = B, 2 = status (bit 0 flag, bit 1 output level).
- R2: With `tb_sel` = 1 all captures and compares use `tb_b`; with `tb_sel` = 0 they use `tb_a`.
- R3: The pin is resynchronized through two flops and an edge is detected one flop later. `edge_pol` = 1 makes rising edges active and `edge_pol` = 0 makes falling edges active. A transition of the other polarity captures nothing in mode 0011.
- R4: Mode 0011 (single capture): each active edge loads the current time base into A and B and sets the flag.
- R5: Mode 0001 (pulse width): the active edge time is held in B1 without setting the flag. At the opposite edge A receives the held start time, B receives the end time, and the flag sets.
- R6: Mode 0010 (period): each active edge moves B into A and loads the time base into B. The flag sets from the second active edge after entering the mode.
- R7: Mode 0100: a time-base change to a value equal to A drives the output to the `edge_pol` level and sets the flag. A count that stays equal does not retrigger.
- R8: Mode 0101: an A match drives the `edge_pol` level and a B match drives the opposite level. Only the B match sets the flag. A bus write to B goes straight to the compare register and reads back.
- R9: Mode 1xxx (PWM): a bus write to B lands in B1 and reads back but has no effect on compares until the next A match, which copies B1 to B2 and drives the `edge_pol` level. A B2 match drives the opposite level and sets the flag. When both match in one cycle, the B level wins.
- R10: `force_a`/`force_b` apply the A/B output action at the next clock, without setting the flag, in modes 0100, 0101 and 1xxx (B only in 0101 and 1xxx). They are ignored in all other modes.
- R11: Input modes, mode 0000 and reserved codes 0110/0111 leave the output level unchanged, even on a compare match.
- R12: Writing status bit 0 = 0 clears the flag only if a status read (`bus_rd`) saw the flag at 1 since the last clear. `irq` is high while the flag is set and `irq_lvl` is nonzero. The flag never sets in mode 0000.
- R13: With `wor_en` = 1, `pin_oe` is low while the output level is 1 (drive-low-only); otherwise `pin_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_a | input | 16 | Time-base count 0 |
| tb_b | input | 16 | Time-base count 1 |
| tb_sel | input | 1 | Selects tb_b when 1 |
| mode | input | 4 | Operating mode code |
| edge_pol | input | 1 | Active edge / output level polarity |
| force_a | input | 1 | Force the A output action |
| force_b | input | 1 | Force the B output action |
| wor_en | input | 1 | Drive-low-only output enable |
| irq_lvl | input | 3 | Interrupt level, 0 disables the request |
| pin_in | input | 1 | Asynchronous input pin |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (status read tracking) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pin_out | output | 1 | Output flip-flop level |
| pin_oe | output | 1 | Output driver enable |
| irq | output | 1 | Interrupt request |

## Verification
Each cycle, the embedded assertions check several invariants. B2 stays still in PWM mode except at an A match, and B1 stays still in the compare modes. The output level stays frozen in input, disabled and reserved modes. The flag only falls after a qualifying status read and never rises while disabled. Capture values, the B1-to-B2 handoff at period start, B-over-A priority, polarity selection, time-base selection and force behaviour depend on scripted pin and count sequences. Only the bench's scenarios show those, comparing bus reads and pin levels against values worked out from the requirements.

// File: rtl/dual_action_timer.sv
module dual_action_timer #(
  parameter int W  = 16,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  tb_a,
  input  logic [W-1:0]  tb_b,
  input  logic          tb_sel,
  input  logic [3:0]    mode,
  input  logic          edge_pol,
  input  logic          force_a,
  input  logic          force_b,
  input  logic          wor_en,
  input  logic [LW-1:0] irq_lvl,
  input  logic          pin_in,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq
);
  logic [W-1:0] reg_a, reg_b1, reg_b2, tb_q;
  logic [2:0]   sync;
  logic [3:0]   mode_q;
  logic         out_ff, flag, flag_seen, armed;
  logic [W-1:0] tb;
  logic         tick, m_a, m_b, lead, trail, is_pwm, is_oca, is_ocab;
  logic         act_a, act_b, ev, clr;

  assign tb      = tb_sel ? tb_b : tb_a;
  assign tick    = tb != tb_q;
  assign m_a     = tick && (tb == reg_a);
  assign m_b     = tick && (tb == reg_b2);
  assign lead    = edge_pol ? (sync[1] & ~sync[2]) : (~sync[1] & sync[2]);
  assign trail   = edge_pol ? (~sync[1] & sync[2]) : (sync[1] & ~sync[2]);
  assign is_pwm  = mode[3];
  assign is_oca  = mode == 4'd4;
  assign is_ocab = mode == 4'd5;
  assign act_a   = (is_oca || is_ocab || is_pwm) && (m_a || force_a);
  assign act_b   = (is_ocab || is_pwm) && (m_b || force_b);
  assign clr     = bus_wr && bus_addr == 2'd2 && !bus_wdata[0] && flag_seen;

  always_comb begin
    case (mode)
      4'd1:    ev = trail;
      4'd2:    ev = lead && armed;
      4'd3:    ev = lead;
      4'd4:    ev = m_a;
      4'd5:    ev = m_b;
      default: ev = is_pwm && m_b;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_a <= '0; reg_b1 <= '0; reg_b2 <= '0; tb_q <= '0;
      sync <= '0; mode_q <= '0; out_ff <= 1'b0;
      flag <= 1'b0; flag_seen <= 1'b0; armed <= 1'b0;
    end else begin
      sync   <= {sync[1:0], pin_in};
      tb_q   <= tb;
      mode_q <= mode;
      if (act_b)      out_ff <= ~edge_pol;
      else if (act_a) out_ff <= edge_pol;

      if (mode != mode_q)         armed <= 1'b0;
      else if (mode == 4'd2 && lead) armed <= 1'b1;

      if (bus_wr && bus_addr == 2'd0) reg_a <= bus_wdata;
      if (bus_wr && bus_addr == 2'd1) begin
        if (is_pwm) reg_b1 <= bus_wdata;
        else        reg_b2 <= bus_wdata;
      end
      if (is_pwm && m_a) reg_b2 <= reg_b1;

      case (mode)
        4'd1: begin
          if (lead)  reg_b1 <= tb;
          if (trail) begin reg_a <= reg_b1; reg_b2 <= tb; end
        end
        4'd2: if (lead) begin reg_a <= reg_b2; reg_b2 <= tb; reg_b1 <= tb; end
        4'd3: if (lead) begin reg_a <= tb; reg_b2 <= tb; reg_b1 <= tb; end
        default: ;
      endcase

      if (ev)       flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (clr)      flag_seen <= 1'b0;
      else if (bus_rd && bus_addr == 2'd2 && flag) flag_seen <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = reg_a;
      2'd1:    bus_rdata = is_pwm ? reg_b1 : reg_b2;
      2'd2:    bus_rdata = {{(W-2){1'b0}}, out_ff, flag};
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = out_ff;
  assign pin_oe  = ~wor_en | ~out_ff;
  assign irq     = flag && (|irq_lvl);

  a_r9_b2_only_at_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3] && !m_a) |=> $stable(reg_b2));
  a_r8_b1_idle_in_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (is_oca || is_ocab) |=> $stable(reg_b1));
  a_r11_reserved_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd6 || mode == 4'd7 || mode == 4'd0) |=> $stable(out_ff));
  a_r11_input_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd1 || mode == 4'd2 || mode == 4'd3) |=> $stable(out_ff));
  a_r12_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_seen));
  a_r12_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |=> !$rose(flag));
endmodule

// File: tb/tb_dual_action_timer.sv
`timescale 1ns/1ps
module tb_dual_action_timer;
  localparam int CLK = 4;
  logic clk = 0, rst_n = 0;
  logic [15:0] tb_a = 0, tb_b = 0, bus_wdata = 0, bus_rdata;
  logic tb_sel = 0, edge_pol = 0, force_a = 0, force_b = 0, wor_en = 0;
  logic [2:0] irq_lvl = 0;
  logic [3:0] mode = 0;
  logic pin_in = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic pin_out, pin_oe, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string tag; int sel; logic [15:0] exp; } item_t;
  item_t q[$];

  always #(CLK/2) clk = ~clk;

  dual_action_timer dut (
    .clk(clk), .rst_n(rst_n), .tb_a(tb_a), .tb_b(tb_b), .tb_sel(tb_sel),
    .mode(mode), .edge_pol(edge_pol), .force_a(force_a), .force_b(force_b),
    .wor_en(wor_en), .irq_lvl(irq_lvl), .pin_in(pin_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = bus_rdata;
        1: act = {15'b0, pin_out};
        2: act = {15'b0, irq};
        default: act = {15'b0, pin_oe};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask
  task automatic rd(logic [1:0] a, logic [15:0] e, string tag);
    bus_addr = a; q.push_back('{tag, 0, e}); cyc();
  endtask
  task automatic chk(int sel, logic [15:0] e, string tag);
    q.push_back('{tag, sel, e}); cyc();
  endtask
  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; cyc(); bus_wr = 0;
  endtask
  task automatic clear_flag();
    bus_addr = 2; bus_rd = 1; cyc(); bus_rd = 0; wr(2, 0);
  endtask

  initial begin
    #(CLK * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(5); rst_n = 1; cyc();
    rd(0, 0, "R1 A"); rd(1, 0, "R1 B"); rd(2, 0, "R1 status");
    chk(1, 0, "R1 pin_out"); chk(2, 0, "R1 irq");

    mode = 3; edge_pol = 1; tb_sel = 1; tb_b = 16'h1234; tb_a = 16'h0055; pin_in = 1; cyc(4);
    rd(0, 16'h1234, "R4 R2 A capture"); rd(1, 16'h1234, "R4 B capture"); rd(2, 1, "R4 flag");
    tb_b = 16'h2222; pin_in = 0; cyc(4);
    rd(0, 16'h1234, "R3 inactive edge ignored");

    wr(2, 0); rd(2, 1, "R12 clear without read ignored");
    chk(2, 0, "R12 irq level zero");
    irq_lvl = 3; chk(2, 1, "R12 irq asserted");
    clear_flag(); rd(2, 0, "R12 flag cleared"); chk(2, 0, "R12 irq dropped");

    edge_pol = 0; tb_b = 16'h3333; pin_in = 1; cyc(4);
    rd(0, 16'h1234, "R3 rising ignored when falling active");
    pin_in = 0; cyc(4);
    rd(0, 16'h3333, "R3 falling capture");
    clear_flag();

    mode = 1; edge_pol = 1; tb_sel = 0; tb_a = 100; pin_in = 1; cyc(4);
    rd(2, 0, "R5 no flag at leading edge");
    tb_a = 150; pin_in = 0; cyc(4);
    rd(0, 100, "R5 start time"); rd(1, 150, "R5 end time"); rd(2, 1, "R5 flag");
    clear_flag();

    mode = 2; tb_a = 200; pin_in = 1; cyc(4);
    rd(2, 0, "R6 first edge no flag");
    pin_in = 0; cyc(4);
    tb_a = 260; pin_in = 1; cyc(4);
    rd(0, 200, "R6 previous edge"); rd(1, 260, "R6 current edge"); rd(2, 1, "R6 flag");
    clear_flag();

    wr(0, 300); mode = 4; edge_pol = 1; cyc();
    chk(1, 0, "R7 before match");
    tb_a = 300; chk(1, 1, "R7 match drives level");
    rd(2, 3, "R7 flag and level");
    clear_flag(); cyc(2);
    rd(2, 2, "R7 no retrigger");
    wor_en = 1; chk(3, 0, "R13 high level not driven");
    wor_en = 0; chk(3, 1, "R13 normal drive");

    mode = 5; edge_pol = 0; wr(0, 400); wr(1, 450);
    rd(1, 450, "R8 B write direct");
    tb_a = 400; chk(1, 0, "R8 A match level");
    rd(2, 0, "R8 no flag on A");
    tb_a = 450; chk(1, 1, "R8 B match level");
    rd(2, 3, "R8 flag on B");
    clear_flag();
    tb_sel = 1; tb_b = 400; chk(1, 0, "R2 compare on tb_b");
    tb_a = 1; cyc(); tb_sel = 0; cyc();

    force_b = 1; cyc(); force_b = 0;
    chk(1, 1, "R10 force B");
    rd(2, 2, "R10 force sets no flag");
    force_a = 1; cyc(); force_a = 0;
    chk(1, 0, "R10 force A");
    mode = 3; force_b = 1; cyc(); force_b = 0;
    chk(1, 0, "R10 force ignored in input mode");
    mode = 6; force_b = 1; cyc(); force_b = 0;
    chk(1, 0, "R11 force ignored in reserved");
    tb_a = 400; chk(1, 0, "R11 match ignored in reserved");

    mode = 8; edge_pol = 1; wr(1, 420);
    rd(1, 420, "R9 B1 readback");
    tb_a = 420; chk(1, 0, "R9 buffered value not active");
    rd(2, 0, "R9 no flag yet");
    tb_a = 400; chk(1, 1, "R9 period start");
    tb_a = 420; chk(1, 0, "R9 new duty active");
    rd(2, 1, "R9 flag"); chk(2, 1, "R12 irq in PWM");
    clear_flag(); chk(2, 0, "R12 irq cleared");
    wr(1, 400); tb_a = 401; cyc();
    tb_a = 400; chk(1, 1, "R9 load equal duty");
    tb_a = 401; cyc();
    tb_a = 400; chk(1, 0, "R9 B wins over A");

    cyc(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule